// File: doc/BRIEF.md
# Stereo Pair Channel Processor

This block sits in the audio path between a routing matrix and a downstream consumer, such as an embedder or a digital audio output. It takes one stereo pair of 24-bit signed samples, qualified by a valid strobe and flagged as audio or non-audio payload. It applies one of eight left/right manipulation modes. A per-pair gain, set in tenths of a decibel, follows. The processed pair leaves a fixed number of cycles later, with the valid strobe delayed by the same amount.

The gain is turned into a linear factor by splitting the setting into whole octaves and a remainder. An octave is 60 tenths of a dB and is applied as a factor of two through a shift. The remainder indexes a computed table of 60 fine steps of 0.1 dB, applied as a fixed-point multiply. The scaled result is rounded half away from zero and saturated to the sample range. Non-audio samples skip both the mode and the gain stage and leave unchanged. Mode and gain are captured together with each sample, so a setting change never affects a sample already in flight.

Top module: `stereo_pair_proc`

## Requirements
- R1: Mode code 0 passes left and right unchanged, code 1 exchanges them, code 2 drives the left input onto both outputs, and code 3 drives the right input onto both outputs.
- R2: Mode code 4 negates the left channel only and code 5 negates the right channel only; negating -8388608 yields +8388607 instead of wrapping.
- R3: Mode code 6 drives floor((L+R)/2) onto both outputs; code 7 drives floor((L+R)/2) on the left and floor((L-R)/2) on the right; neither can exceed the 24-bit range for any input.
- R4: The gain input is a signed count of 0.1 dB steps, clamped to -960..+960. Writing the clamped value as g = 60k + r with 0 <= r < 60, the linear factor is 2^k * 10^(r/200). The fine factor is held to within 2^-16 relative precision.
- R5: A gain of 0 is exactly unity; a gain that is a multiple of 60 scales by exactly 2^k, with results rounded half away from zero (3 at -6.0 dB gives 2, -7 at -12.0 dB gives -2).
- R6: Every gained result saturates to the range -8388608..+8388607.
- R7: A sample with the non-audio flag set leaves bit-exact on both channels, whatever the mode and gain, and out_nonaudio carries the flag.
- R8: out_valid is high exactly three cycles after each cycle with in_valid high and at no other time; every accepted sample produces one output; after reset out_valid is low and the outputs are zero.
- R9: cfg_mode and cfg_gain are sampled only in cycles with in_valid high; values present in other cycles, or changes after a sample is accepted, do not alter that sample's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input pair is present this cycle |
| in_left | input | 24 | Left input sample, two's complement |
| in_right | input | 24 | Right input sample, two's complement |
| in_nonaudio | input | 1 | Input pair carries non-audio payload |
| cfg_mode | input | 3 | Channel manipulation mode code (R1-R3 encodings) |
| cfg_gain | input | 16 | Signed gain in 0.1 dB steps |
| out_valid | output | 1 | Output pair is present this cycle |
| out_left | output | 24 | Processed left sample |
| out_right | output | 24 | Processed right sample |
| out_nonaudio | output | 1 | Output pair carries non-audio payload |

## Verification
On every cycle, the assertions check several things. The three-cycle valid delay must hold. Non-audio pairs must come out equal to the pair that went in three cycles before, and unity-gain pass mode must leave data untouched. The captured mode and gain must hold while no sample is offered. Left-copy mode must give matching channels, and negating the most negative value must saturate. The exact values of the swap and sum/difference modes, the fine 0.1 dB scaling, half-away rounding, saturation at both rails and gain clamping can only be shown by the bench's scenarios. Those scenarios compare each output against a value computed independently from the requirements. The same holds for the fact that out-of-sample configuration noise has no effect.

// File: rtl/spp_pkg.sv
package spp_pkg;

  parameter int SAMPLE_W       = 24;
  parameter int GAIN_W         = 16;
  parameter int COEF_FRAC      = 16;
  parameter int TENTHS_PER_OCT = 60;
  parameter int GAIN_LIMIT     = 960;
  parameter int NUM_CH         = 2;

  localparam int COEF_W    = COEF_FRAC + 1;
  localparam int OCT_LIMIT = GAIN_LIMIT / TENTHS_PER_OCT;
  localparam int SHIFT_W   = $clog2(COEF_FRAC + OCT_LIMIT + 1);
  localparam int PROD_W    = SAMPLE_W + COEF_W + 1;
  localparam int ROM_IDX_W = $clog2(TENTHS_PER_OCT);

  // 10^(1/200) in Q30: one 0.1 dB step
  localparam logic [63:0] STEP_Q30 = 64'd1086175168;

  typedef logic signed [SAMPLE_W-1:0] sample_t;

  localparam sample_t S_MAX = {1'b0, {(SAMPLE_W-1){1'b1}}};
  localparam sample_t S_MIN = {1'b1, {(SAMPLE_W-1){1'b0}}};

  typedef enum logic [2:0] {
    CH_PASS       = 3'd0,
    CH_SWAP       = 3'd1,
    CH_LEFT_BOTH  = 3'd2,
    CH_RIGHT_BOTH = 3'd3,
    CH_INV_LEFT   = 3'd4,
    CH_INV_RIGHT  = 3'd5,
    CH_MONO       = 3'd6,
    CH_MIDSIDE    = 3'd7
  } chan_mode_e;

  typedef struct packed {
    sample_t left;
    sample_t right;
  } pair_t;

  // Negation that clips the single unrepresentable case
  function automatic sample_t negate_sat(sample_t x);
    return (x == S_MIN) ? S_MAX : -x;
  endfunction

  // floor((a +/- b) / 2) computed in one extra bit, never overflows
  function automatic sample_t half_combine(sample_t a, sample_t b, logic diff);
    logic signed [SAMPLE_W:0] wide;
    if (diff) wide = {a[SAMPLE_W-1], a} - {b[SAMPLE_W-1], b};
    else      wide = {a[SAMPLE_W-1], a} + {b[SAMPLE_W-1], b};
    return wide[SAMPLE_W:1];
  endfunction

  function automatic pair_t apply_mode(chan_mode_e m, pair_t x);
    pair_t y;
    case (m)
      CH_PASS:       y = x;
      CH_SWAP:       begin y.left = x.right; y.right = x.left; end
      CH_LEFT_BOTH:  begin y.left = x.left;  y.right = x.left; end
      CH_RIGHT_BOTH: begin y.left = x.right; y.right = x.right; end
      CH_INV_LEFT:   begin y.left = negate_sat(x.left); y.right = x.right; end
      CH_INV_RIGHT:  begin y.left = x.left; y.right = negate_sat(x.right); end
      CH_MONO:       begin
        y.left  = half_combine(x.left, x.right, 1'b0);
        y.right = y.left;
      end
      default:       begin
        y.left  = half_combine(x.left, x.right, 1'b0);
        y.right = half_combine(x.left, x.right, 1'b1);
      end
    endcase
    return y;
  endfunction

  // Fine gain coefficient for idx tenths of a dB, unsigned Q(COEF_FRAC)
  function automatic logic [COEF_W-1:0] coef_of(int idx);
    logic [63:0] acc;
    acc = 64'd1 << 30;
    for (int i = 0; i < idx; i++) begin
      acc = (acc * STEP_Q30 + (64'd1 << 29)) >> 30;
    end
    return COEF_W'((acc + (64'd1 << (29 - COEF_FRAC))) >> (30 - COEF_FRAC));
  endfunction

  // Right shift with round half away from zero, then clip to sample range
  function automatic sample_t round_shift_sat(logic signed [PROD_W-1:0] p,
                                              logic [SHIFT_W-1:0] sh);
    logic [PROD_W:0] mag;
    logic [PROD_W:0] half;
    logic [PROD_W:0] rounded;
    logic [PROD_W:0] mag_max;
    logic            neg;
    neg     = p[PROD_W-1];
    mag     = neg ? {1'b0, -p} : {1'b0, p};
    half    = (sh == '0) ? '0 : ((PROD_W+1)'(1) << (sh - 1'b1));
    rounded = (mag + half) >> sh;
    mag_max = (PROD_W+1)'(S_MAX);
    if (!neg) begin
      return (rounded > mag_max) ? S_MAX : sample_t'(rounded);
    end
    return (rounded > mag_max) ? S_MIN : -sample_t'(rounded);
  endfunction

endpackage

// File: rtl/spp_mode_mux.sv
module spp_mode_mux
  import spp_pkg::*;
(
  input  logic [2:0]            mode,
  input  logic                  bypass,
  input  logic signed [SAMPLE_W-1:0] left_in,
  input  logic signed [SAMPLE_W-1:0] right_in,
  output logic signed [SAMPLE_W-1:0] left_out,
  output logic signed [SAMPLE_W-1:0] right_out
);

  pair_t raw_pair;
  pair_t moded_pair;

  always_comb begin
    raw_pair.left  = left_in;
    raw_pair.right = right_in;
    moded_pair     = apply_mode(chan_mode_e'(mode), raw_pair);
    if (bypass) begin
      left_out  = left_in;
      right_out = right_in;
    end else begin
      left_out  = moded_pair.left;
      right_out = moded_pair.right;
    end
  end

endmodule

// File: rtl/spp_gain_split.sv
module spp_gain_split
  import spp_pkg::*;
(
  input  logic signed [GAIN_W-1:0] gain_db10,
  output logic [COEF_W-1:0]        coef,
  output logic [SHIFT_W-1:0]       shift
);

  localparam logic signed [GAIN_W-1:0] LIM_POS = GAIN_W'(GAIN_LIMIT);
  localparam logic signed [GAIN_W-1:0] LIM_NEG = -GAIN_W'(GAIN_LIMIT);
  localparam logic [GAIN_W-1:0]        OCT_U   = GAIN_W'(TENTHS_PER_OCT);
  localparam logic [SHIFT_W-1:0]       SH_TOP  = SHIFT_W'(COEF_FRAC + OCT_LIMIT);

  logic [COEF_W-1:0] coef_rom [TENTHS_PER_OCT];

  for (genvar i = 0; i < TENTHS_PER_OCT; i++) begin : g_rom
    assign coef_rom[i] = coef_of(i);
  end

  logic signed [GAIN_W-1:0] g_clamp;
  logic [GAIN_W-1:0]        g_ofs;
  logic [GAIN_W-1:0]        oct_q;
  logic [GAIN_W-1:0]        rem_q;

  always_comb begin
    if (gain_db10 > LIM_POS)      g_clamp = LIM_POS;
    else if (gain_db10 < LIM_NEG) g_clamp = LIM_NEG;
    else                          g_clamp = gain_db10;
    g_ofs = g_clamp + LIM_POS;
    oct_q = g_ofs / OCT_U;
    rem_q = g_ofs % OCT_U;
    shift = SH_TOP - oct_q[SHIFT_W-1:0];
    coef  = coef_rom[rem_q[ROM_IDX_W-1:0]];
  end

endmodule

// File: rtl/spp_gain_lane.sv
module spp_gain_lane
  import spp_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       mul_en,
  input  logic                       out_en,
  input  logic signed [SAMPLE_W-1:0] x,
  input  logic [COEF_W-1:0]          coef,
  input  logic [SHIFT_W-1:0]         shift,
  input  logic                       bypass,
  output logic signed [SAMPLE_W-1:0] y
);

  logic signed [PROD_W-1:0] x_ext;
  logic signed [PROD_W-1:0] c_ext;
  logic signed [PROD_W-1:0] prod;

  logic signed [PROD_W-1:0] p2_prod;
  logic [SHIFT_W-1:0]       p2_shift;
  logic                     p2_bypass;
  logic signed [SAMPLE_W-1:0] p2_raw;

  always_comb begin
    x_ext = PROD_W'(x);
    c_ext = PROD_W'($signed({1'b0, coef}));
    prod  = x_ext * c_ext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p2_prod   <= '0;
      p2_shift  <= '0;
      p2_bypass <= 1'b0;
      p2_raw    <= '0;
    end else if (mul_en) begin
      p2_prod   <= prod;
      p2_shift  <= shift;
      p2_bypass <= bypass;
      p2_raw    <= x;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y <= '0;
    end else if (out_en) begin
      y <= p2_bypass ? p2_raw : round_shift_sat(p2_prod, p2_shift);
    end
  end

endmodule

// File: rtl/stereo_pair_proc.sv
module stereo_pair_proc
  import spp_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic signed [SAMPLE_W-1:0] in_left,
  input  logic signed [SAMPLE_W-1:0] in_right,
  input  logic                       in_nonaudio,
  input  logic [2:0]                 cfg_mode,
  input  logic signed [GAIN_W-1:0]   cfg_gain,
  output logic                       out_valid,
  output logic signed [SAMPLE_W-1:0] out_left,
  output logic signed [SAMPLE_W-1:0] out_right,
  output logic                       out_nonaudio
);

  // Stage 0 combinational results
  logic signed [SAMPLE_W-1:0] mx_left;
  logic signed [SAMPLE_W-1:0] mx_right;
  logic [COEF_W-1:0]          gs_coef;
  logic [SHIFT_W-1:0]         gs_shift;

  // Stage 1 registers: moded pair plus gain captured with the sample
  logic                       s1_valid;
  logic                       s1_nonaudio;
  logic signed [SAMPLE_W-1:0] s1_left;
  logic signed [SAMPLE_W-1:0] s1_right;
  logic [COEF_W-1:0]          s1_coef;
  logic [SHIFT_W-1:0]         s1_shift;

  // Stage 2 control
  logic                       p2_valid;
  logic                       p2_nonaudio;

  logic signed [SAMPLE_W-1:0] lane_x [NUM_CH];
  logic signed [SAMPLE_W-1:0] lane_y [NUM_CH];

  spp_mode_mux u_mode_mux (
    .mode      (cfg_mode),
    .bypass    (in_nonaudio),
    .left_in   (in_left),
    .right_in  (in_right),
    .left_out  (mx_left),
    .right_out (mx_right)
  );

  spp_gain_split u_gain_split (
    .gain_db10 (cfg_gain),
    .coef      (gs_coef),
    .shift     (gs_shift)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid    <= 1'b0;
      s1_nonaudio <= 1'b0;
      s1_left     <= '0;
      s1_right    <= '0;
      s1_coef     <= '0;
      s1_shift    <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_nonaudio <= in_nonaudio;
        s1_left     <= mx_left;
        s1_right    <= mx_right;
        s1_coef     <= gs_coef;
        s1_shift    <= gs_shift;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p2_valid     <= 1'b0;
      p2_nonaudio  <= 1'b0;
      out_valid    <= 1'b0;
      out_nonaudio <= 1'b0;
    end else begin
      p2_valid  <= s1_valid;
      out_valid <= p2_valid;
      if (s1_valid) p2_nonaudio  <= s1_nonaudio;
      if (p2_valid) out_nonaudio <= p2_nonaudio;
    end
  end

  assign lane_x[0] = s1_left;
  assign lane_x[1] = s1_right;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lane
    spp_gain_lane u_lane (
      .clk    (clk),
      .rst_n  (rst_n),
      .mul_en (s1_valid),
      .out_en (p2_valid),
      .x      (lane_x[ch]),
      .coef   (s1_coef),
      .shift  (s1_shift),
      .bypass (s1_nonaudio),
      .y      (lane_y[ch])
    );
  end

  assign out_left  = lane_y[0];
  assign out_right = lane_y[1];

endmodule

// File: rtl/spp_checker.sv
module spp_checker
  import spp_pkg::*;
(
  input logic                       clk,
  input logic                       rst_n,
  input logic                       in_valid,
  input logic signed [SAMPLE_W-1:0] in_left,
  input logic signed [SAMPLE_W-1:0] in_right,
  input logic                       in_nonaudio,
  input logic [2:0]                 cfg_mode,
  input logic signed [GAIN_W-1:0]   cfg_gain,
  input logic                       out_valid,
  input logic signed [SAMPLE_W-1:0] out_left,
  input logic signed [SAMPLE_W-1:0] out_right,
  input logic                       out_nonaudio,
  input logic                       s1_valid,
  input logic signed [SAMPLE_W-1:0] s1_left,
  input logic signed [SAMPLE_W-1:0] s1_right,
  input logic [COEF_W-1:0]          s1_coef,
  input logic [SHIFT_W-1:0]         s1_shift
);

  // Cycles since reset, saturating at the pipeline depth
  logic [1:0] since_rst;
  logic       armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end
  assign armed = (since_rst == 2'd3);

  p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (out_valid == $past(in_valid, 3)));

  p_nonaudio_exact_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && out_valid && out_nonaudio) |->
      (out_left == $past(in_left, 3) && out_right == $past(in_right, 3)));

  p_unity_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && out_valid && $past(in_valid, 3) && !$past(in_nonaudio, 3) &&
     $past(cfg_gain, 3) == '0 && $past(cfg_mode, 3) == 3'd0) |->
      (out_left == $past(in_left, 3) && out_right == $past(in_right, 3)));

  p_invert_sat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_nonaudio && cfg_mode == 3'd4 && in_left == S_MIN) |=>
      (s1_left == S_MAX));

  p_copy_left_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_nonaudio && cfg_mode == 3'd2) |=>
      (s1_left == s1_right && s1_left == $past(in_left)));

  p_hold_cfg_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(s1_coef) && $stable(s1_shift) && !s1_valid));

endmodule

bind stereo_pair_proc spp_checker u_spp_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_left      (in_left),
  .in_right     (in_right),
  .in_nonaudio  (in_nonaudio),
  .cfg_mode     (cfg_mode),
  .cfg_gain     (cfg_gain),
  .out_valid    (out_valid),
  .out_left     (out_left),
  .out_right    (out_right),
  .out_nonaudio (out_nonaudio),
  .s1_valid     (s1_valid),
  .s1_left      (s1_left),
  .s1_right     (s1_right),
  .s1_coef      (s1_coef),
  .s1_shift     (s1_shift)
);

// File: tb/stereo_pair_proc_bench.sv
module stereo_pair_proc_bench;

  localparam int CLK_PERIOD = 10;
  localparam int TOP = 8388607;
  localparam int BOT = -8388608;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic               rst_n;
  logic               in_valid;
  logic signed [23:0] in_left;
  logic signed [23:0] in_right;
  logic               in_nonaudio;
  logic [2:0]         cfg_mode;
  logic signed [15:0] cfg_gain;
  logic               out_valid;
  logic signed [23:0] out_left;
  logic signed [23:0] out_right;
  logic               out_nonaudio;

  stereo_pair_proc u_stereo_pair_proc (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_left      (in_left),
    .in_right     (in_right),
    .in_nonaudio  (in_nonaudio),
    .cfg_mode     (cfg_mode),
    .cfg_gain     (cfg_gain),
    .out_valid    (out_valid),
    .out_left     (out_left),
    .out_right    (out_right),
    .out_nonaudio (out_nonaudio)
  );

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 0;

  int    q_l[$];
  int    q_r[$];
  int    q_tol[$];
  bit    q_na[$];
  string q_tag[$];

  function automatic int flip(int v);
    return (v == BOT) ? TOP : -v;
  endfunction

  function automatic int mag(int v);
    return (v < 0) ? -v : v;
  endfunction

  // Scale by the dB rule of R4/R5, round half away, clip per R6
  function automatic int scaled(int x, int g, output int tol);
    int  gc, k, rr;
    real f, e, v;
    gc = g;
    if (gc > 960)  gc = 960;
    if (gc < -960) gc = -960;
    k  = $rtoi($floor(real'(gc) / 60.0));
    rr = gc - 60 * k;
    f  = (2.0 ** real'(k)) * (10.0 ** (real'(rr) / 200.0));
    e  = real'(x) * f;
    if (e >= 0.0) v = $floor(e + 0.5);
    else          v = -$floor(-e + 0.5);
    if (v > real'(TOP)) v = real'(TOP);
    if (v < real'(BOT)) v = real'(BOT);
    scaled = $rtoi(v);
    tol = (rr == 0) ? 0 : 2 + (mag(scaled) >>> 14);
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Driver: compute the expected pair, queue it, present the sample
  task automatic send(int l, int r, bit na, int mode, int gain, string tag);
    int a, b, ta, tb;
    case (mode)
      0: begin a = l; b = r; end
      1: begin a = r; b = l; end
      2: begin a = l; b = l; end
      3: begin a = r; b = r; end
      4: begin a = flip(l); b = r; end
      5: begin a = l; b = flip(r); end
      6: begin a = (l + r) >>> 1; b = a; end
      default: begin a = (l + r) >>> 1; b = (l - r) >>> 1; end
    endcase
    if (na) begin
      a = l; b = r; ta = 0; tb = 0;
    end else begin
      a = scaled(a, gain, ta);
      b = scaled(b, gain, tb);
    end
    q_l.push_back(a);
    q_r.push_back(b);
    q_tol.push_back((ta > tb) ? ta : tb);
    q_na.push_back(na);
    q_tag.push_back(tag);
    @(negedge clk);
    in_valid    = 1'b1;
    in_left     = 24'(l);
    in_right    = 24'(r);
    in_nonaudio = na;
    cfg_mode    = 3'(mode);
    cfg_gain    = 16'(gain);
  endtask

  // Idle cycles carry junk configuration that must be ignored (R9)
  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid    = 1'b0;
      in_nonaudio = ~in_nonaudio;
      cfg_mode    = 3'(i * 3 + 5);
      cfg_gain    = 16'(i * 331 - 700);
      in_left     = 24'(i * 99991);
    end
  endtask

  // Monitor: pop and compare whenever the block presents a result
  always @(negedge clk) begin
    if (rst_n && out_valid && !done) begin
      if (q_l.size() == 0) begin
        check(1'b0, "R8", "unexpected out_valid", 1, 0);
      end else begin
        int    el, er, tl;
        bit    en;
        string tg;
        el = q_l.pop_front();
        er = q_r.pop_front();
        tl = q_tol.pop_front();
        en = q_na.pop_front();
        tg = q_tag.pop_front();
        check(mag(int'(out_left) - el) <= tl, tg, "left", int'(out_left), el);
        check(mag(int'(out_right) - er) <= tl, tg, "right", int'(out_right), er);
        check(out_nonaudio == en, tg, "nonaudio flag", int'(out_nonaudio), int'(en));
      end
    end
  end

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    int seed;
    rst_n = 1'b0; in_valid = 1'b0; in_left = '0; in_right = '0;
    in_nonaudio = 1'b0; cfg_mode = '0; cfg_gain = '0;
    repeat (3) @(negedge clk);
    // R8: reset state
    check(out_valid == 1'b0, "R8", "reset out_valid", int'(out_valid), 0);
    check(out_left == '0 && out_right == '0, "R8", "reset data",
          int'(out_left), 0);
    rst_n = 1'b1;
    idle(2);

    // R8: a lone sample appears on the third cycle
    send(1000, -2000, 0, 0, 0, "R8");
    @(negedge clk); in_valid = 1'b0;
    check(out_valid == 1'b0, "R8", "valid after 1 cycle", int'(out_valid), 0);
    @(negedge clk);
    check(out_valid == 1'b0, "R8", "valid after 2 cycles", int'(out_valid), 0);
    @(negedge clk);
    check(out_valid == 1'b1, "R8", "valid after 3 cycles", int'(out_valid), 1);
    idle(3);

    // R1, R2, R3: every mode back to back at unity gain
    send(123456, -654321, 0, 0, 0, "R1");
    send(123456, -654321, 0, 1, 0, "R1");
    send(123456, -654321, 0, 2, 0, "R1");
    send(123456, -654321, 0, 3, 0, "R1");
    send(123456, -654321, 0, 4, 0, "R2");
    send(123456, -654321, 0, 5, 0, "R2");
    send(123456, -654321, 0, 6, 0, "R3");
    send(123456, -654321, 0, 7, 0, "R3");
    idle(4);

    // R2: negating the most negative value saturates
    send(BOT, 5, 0, 4, 0, "R2");
    send(7, BOT, 0, 5, 0, "R2");
    // R3: sums at the rails, floor rounding
    send(TOP, TOP, 0, 6, 0, "R3");
    send(BOT, BOT, 0, 6, 0, "R3");
    send(TOP, BOT, 0, 7, 0, "R3");
    send(3, -4, 0, 6, 0, "R3");
    idle(3);

    // R5: exact octave scaling with half-away rounding
    send(3, -3, 0, 0, -60, "R5");
    send(5, -7, 0, 0, -120, "R5");
    send(1, -1, 0, 0, -960, "R5");
    // R6: saturation on both rails
    send(5000000, -5000000, 0, 0, 60, "R6");
    send(TOP, BOT, 0, 1, 960, "R6");
    // R4: clamp and fine steps
    send(1, -1, 0, 0, 1000, "R4");
    send(1, -1, 0, 0, -2000, "R4");
    send(4000000, -4000000, 0, 0, -400, "R4");
    send(100000, 3, 0, 1, 57, "R4");
    idle(2);

    // R7: non-audio payload is untouched
    send(BOT, TOP, 1, 4, 600, "R7");
    send(12345, -1, 1, 6, -960, "R7");
    idle(5);

    // R9: junk config in idle cycles, then unity pass must be exact
    send(-777, 888, 0, 0, 0, "R9");
    idle(1);
    send(-777, 888, 0, 3, -60, "R9");
    send(-777, 888, 0, 0, 0, "R9");
    idle(4);

    // R4: mixed stream of modes, gains and payload types
    seed = 32'h1234_5678;
    for (int i = 0; i < 48; i++) begin
      logic signed [23:0] va, vb;
      seed = seed * 1103515245 + 12345;
      va = seed[31:8];
      seed = seed * 1103515245 + 12345;
      vb = seed[31:8];
      send(int'(va), int'(vb), (i % 7) == 3, i % 8, ((i * 137) % 1921) - 960, "R4");
      if ((i % 5) == 4) idle(1);
    end
    idle(8);

    // R8: one output for every accepted sample
    check(q_l.size() == 0, "R8", "outstanding samples", q_l.size(), 0);
    finish_run();
  end

endmodule